// File: doc/BRIEF.md
# Byte-serial market message decoder

This block turns a byte-serial stream of exchange market-data messages into decoded order events. One byte comes in on each clock in which `in_valid` is high. `in_sop` marks the first byte of a message, and that byte is the message-type code. The code alone selects the length of the message and where each field sits inside it. The block handles four kinds of message: a new order, a fill against an order, a partial cancel and a full removal. Any other code is consumed and dropped.

As bytes arrive, a byte counter steers each one into the field it belongs to. Fields are big-endian, so each byte shifts into the low end of its accumulator. When the final byte of a supported message has been taken, the block raises `evt_valid` for one cycle. In that cycle it presents the type code, the order reference, the side, the share count and the price. Network, transport and packet-envelope handling all happen upstream of this block.

Top module: `mkt_msg_decoder`

## Requirements
- R1: After reset `evt_valid` is 0 and every event field output (`evt_type`, `evt_ref`, `evt_sell`, `evt_shares`, `evt_price`) is 0.
- R2: A message whose first byte is 0x41 ('A') is 36 bytes long, with the type code at byte index 0. Its event carries the reference from bytes 11..18, the share count from bytes 20..23 and the price from bytes 32..35. `evt_sell` is 1 when byte 19 is 0x53 ('S') and 0 for any other value, including 0x42 ('B').
- R3: A message with first byte 0x45 ('E') is 31 bytes long. Its event carries the reference from bytes 11..18 and the share count from bytes 19..22, with `evt_sell` = 0 and `evt_price` = 0.
- R4: A message with first byte 0x58 ('X') is 23 bytes long. Its event carries the reference from bytes 11..18 and the share count from bytes 19..22, with `evt_sell` = 0 and `evt_price` = 0.
- R5: A message with first byte 0x44 ('D') is 19 bytes long. Its event carries the reference from bytes 11..18, with `evt_shares`, `evt_sell` and `evt_price` all 0.
- R6: `evt_valid` is high for exactly one cycle, namely the cycle after the clock edge that takes the final byte, and `evt_type` then equals the message's first byte. While `evt_valid` is low, all event field outputs are 0.
- R7: Every multi-byte field is big-endian: the lowest-indexed byte of a field becomes its most significant byte.
- R8: A start byte that is not one of the four codes starts no event. All bytes up to the next byte that has both `in_valid` and `in_sop` high are dropped.
- R9: A byte with `in_valid` and `in_sop` both high always starts a new message, even in the middle of another. The interrupted message produces no event.
- R10: Cycles with `in_valid` low are ignored whatever `in_sop` and `in_byte` carry. Bytes with `in_valid` high and `in_sop` low that arrive outside a message are dropped.
- R11: Byte positions count only accepted bytes, so idle cycles inside a message do not change the decoded fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_byte` is present this cycle |
| in_sop | input | 1 | Byte is the first (type) byte of a message |
| in_byte | input | 8 | Stream byte |
| evt_valid | output | 1 | One-cycle decoded event strobe |
| evt_type | output | 8 | Type code of the decoded message |
| evt_ref | output | 64 | Order reference |
| evt_sell | output | 1 | 1 = sell side (new-order messages only) |
| evt_shares | output | 32 | Share count (added, executed or cancelled) |
| evt_price | output | 32 | Price, fixed point with four decimals (new-order messages only) |

## Verification
The assertions assume that every message starts with a byte carrying `in_sop`. They also assume that no two events can fall on adjacent cycles, which holds because even the shortest message takes 19 accepted bytes. The stimulus builds each message from its field values using the byte layout in the requirements. It marks only index 0 as a start byte, and it places idle cycles only between accepted bytes. Those idle cycles carry deliberately misleading `in_sop` and `in_byte` values, so the bench can show that such cycles are ignored.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

    localparam int BYTE_W     = 8;

    // message lengths in bytes, type byte included
    localparam int LEN_ADD    = 36;
    localparam int LEN_EXEC   = 31;
    localparam int LEN_CANCEL = 23;
    localparam int LEN_DELETE = 19;
    localparam int MAX_LEN    = LEN_ADD;
    localparam int CNT_W      = $clog2(MAX_LEN);

    // field placement (byte index, type byte at index 0)
    localparam int REF_LO     = 11;
    localparam int REF_BYTES  = 8;
    localparam int SIDE_AT    = 19;
    localparam int QTY_LO_ADD = 20;
    localparam int QTY_LO_MOD = 19;
    localparam int QTY_BYTES  = 4;
    localparam int PX_LO      = 32;
    localparam int PX_BYTES   = 4;

    localparam int REF_W      = REF_BYTES * BYTE_W;
    localparam int QTY_W      = QTY_BYTES * BYTE_W;
    localparam int PX_W       = PX_BYTES * BYTE_W;

    localparam logic [BYTE_W-1:0] CODE_ADD    = 8'h41;
    localparam logic [BYTE_W-1:0] CODE_EXEC   = 8'h45;
    localparam logic [BYTE_W-1:0] CODE_CANCEL = 8'h58;
    localparam logic [BYTE_W-1:0] CODE_DELETE = 8'h44;
    localparam logic [BYTE_W-1:0] CODE_SELL   = 8'h53;

    typedef enum logic [1:0] {K_ADD, K_EXEC, K_CANCEL, K_DELETE} kind_e;
    typedef enum logic {S_IDLE, S_RECV} phase_e;

endpackage

// File: rtl/mmd_type_lut.sv
module mmd_type_lut
    import mmd_pkg::*;
(
    input  logic [BYTE_W-1:0] code,
    output logic              hit,
    output kind_e             kind,
    output logic [CNT_W-1:0]  last_idx
);
    always_comb begin
        hit      = 1'b1;
        kind     = K_ADD;
        last_idx = '0;
        case (code)
            CODE_ADD: begin
                kind     = K_ADD;
                last_idx = CNT_W'(LEN_ADD - 1);
            end
            CODE_EXEC: begin
                kind     = K_EXEC;
                last_idx = CNT_W'(LEN_EXEC - 1);
            end
            CODE_CANCEL: begin
                kind     = K_CANCEL;
                last_idx = CNT_W'(LEN_CANCEL - 1);
            end
            CODE_DELETE: begin
                kind     = K_DELETE;
                last_idx = CNT_W'(LEN_DELETE - 1);
            end
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/mmd_field_sel.sv
module mmd_field_sel
    import mmd_pkg::*;
(
    input  logic             active,
    input  kind_e            kind,
    input  logic [CNT_W-1:0] idx,
    output logic             en_ref,
    output logic             en_qty,
    output logic             en_px,
    output logic             en_side
);
    int pos;
    int qty_lo;
    logic has_qty;

    always_comb begin
        pos     = int'(idx);
        qty_lo  = (kind == K_ADD) ? QTY_LO_ADD : QTY_LO_MOD;
        has_qty = (kind != K_DELETE);
        en_ref  = active && (pos >= REF_LO) && (pos < REF_LO + REF_BYTES);
        en_qty  = active && has_qty && (pos >= qty_lo) && (pos < qty_lo + QTY_BYTES);
        en_px   = active && (kind == K_ADD) && (pos >= PX_LO) && (pos < PX_LO + PX_BYTES);
        en_side = active && (kind == K_ADD) && (pos == SIDE_AT);
    end
endmodule

// File: rtl/mmd_shift_acc.sv
module mmd_shift_acc
    import mmd_pkg::*;
#(
    parameter int BYTES = 4,
    localparam int W    = BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic [W-1:0]      acc
);
    logic [W-1:0] acc_d, acc_q;
    logic [W-1:0] shifted;

    generate
        if (BYTES == 1) begin : g_single
            always_comb shifted = din;
        end else begin : g_multi
            always_comb shifted = {acc_q[W-BYTE_W-1:0], din};
        end
    endgenerate

    always_comb begin
        acc_d = acc_q;
        if (en) acc_d = shifted;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q)); // R10
endmodule

// File: rtl/mkt_msg_decoder.sv
module mkt_msg_decoder
    import mmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              evt_valid,
    output logic [BYTE_W-1:0] evt_type,
    output logic [REF_W-1:0]  evt_ref,
    output logic              evt_sell,
    output logic [QTY_W-1:0]  evt_shares,
    output logic [PX_W-1:0]   evt_price
);
    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  idx;
        logic [CNT_W-1:0]  last;
        kind_e             kind;
        logic [BYTE_W-1:0] code;
        logic              sell;
        logic              fire;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             lut_hit;
    kind_e            lut_kind;
    logic [CNT_W-1:0] lut_last;
    logic             take_sop;
    logic             take_body;
    logic             en_ref, en_qty, en_px, en_side;
    logic [REF_W-1:0] ref_acc;
    logic [QTY_W-1:0] qty_acc;
    logic [PX_W-1:0]  px_acc;

    assign take_sop  = in_valid && in_sop;
    assign take_body = in_valid && !in_sop && (ctl_q.ph == S_RECV);

    mmd_type_lut u_lut (
        .code     (in_byte),
        .hit      (lut_hit),
        .kind     (lut_kind),
        .last_idx (lut_last)
    );

    mmd_field_sel u_sel (
        .active  (take_body),
        .kind    (ctl_q.kind),
        .idx     (ctl_q.idx),
        .en_ref  (en_ref),
        .en_qty  (en_qty),
        .en_px   (en_px),
        .en_side (en_side)
    );

    mmd_shift_acc #(.BYTES(REF_BYTES)) u_ref (
        .clk (clk), .rst_n (rst_n), .en (en_ref), .din (in_byte), .acc (ref_acc)
    );

    mmd_shift_acc #(.BYTES(QTY_BYTES)) u_qty (
        .clk (clk), .rst_n (rst_n), .en (en_qty), .din (in_byte), .acc (qty_acc)
    );

    mmd_shift_acc #(.BYTES(PX_BYTES)) u_px (
        .clk (clk), .rst_n (rst_n), .en (en_px), .din (in_byte), .acc (px_acc)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.fire = 1'b0;
        if (take_sop) begin
            if (lut_hit) begin
                ctl_d.ph   = S_RECV;
                ctl_d.idx  = CNT_W'(1);
                ctl_d.last = lut_last;
                ctl_d.kind = lut_kind;
                ctl_d.code = in_byte;
                ctl_d.sell = 1'b0;
            end else begin
                ctl_d.ph = S_IDLE;
            end
        end else if (take_body) begin
            if (en_side) ctl_d.sell = (in_byte == CODE_SELL);
            if (ctl_q.idx == ctl_q.last) begin
                ctl_d.ph   = S_IDLE;
                ctl_d.fire = 1'b1;
            end else begin
                ctl_d.idx = ctl_q.idx + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.ph   <= S_IDLE;
            ctl_q.kind <= K_ADD;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign evt_valid  = ctl_q.fire;
    assign evt_type   = ctl_q.fire ? ctl_q.code : '0;
    assign evt_ref    = ctl_q.fire ? ref_acc : '0;
    assign evt_sell   = ctl_q.fire && (ctl_q.kind == K_ADD) && ctl_q.sell;
    assign evt_shares = (ctl_q.fire && ctl_q.kind != K_DELETE) ? qty_acc : '0;
    assign evt_price  = (ctl_q.fire && ctl_q.kind == K_ADD) ? px_acc : '0;

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid); // R6

    AST_EVT_FROM_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(in_valid && !in_sop)); // R6

    AST_SOP_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop) |=> !evt_valid); // R9

    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && !lut_hit) |=> (ctl_q.ph == S_IDLE)); // R8

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == S_RECV) |-> (ctl_q.idx != '0 && ctl_q.idx <= ctl_q.last)); // R11

    AST_SIDE_ADD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_sell |-> (evt_type == CODE_ADD)); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |-> (evt_ref == '0 && evt_shares == '0 && evt_price == '0)); // R6
endmodule

// File: tb/mkt_msg_decoder_tb.sv
`timescale 1ns/1ps
module mkt_msg_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_sop;
    logic [7:0]  in_byte;
    logic        evt_valid, evt_sell;
    logic [7:0]  evt_type;
    logic [63:0] evt_ref;
    logic [31:0] evt_shares, evt_price;

    always #2.5 clk = ~clk;

    mkt_msg_decoder u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_sop (in_sop),
        .in_byte (in_byte), .evt_valid (evt_valid), .evt_type (evt_type),
        .evt_ref (evt_ref), .evt_sell (evt_sell), .evt_shares (evt_shares),
        .evt_price (evt_price)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    int  ev_cnt = 0;
    bit  done = 1'b0;

    always @(negedge clk) if (rst_n && evt_valid) ev_cnt++;

    typedef struct packed {
        logic [7:0]  t;
        logic [63:0] r;
        logic        s;
        logic [31:0] q;
        logic [31:0] p;
        logic [7:0]  gap;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{8'h41, 64'h0123456789ABCDEF, 1'b0, 32'd100,        32'd1523400,  8'd0},
        '{8'h41, 64'hFEDCBA9876543210, 1'b1, 32'hFFFFFFFF,   32'h80000001, 8'd25},
        '{8'h45, 64'h0000000000000001, 1'b0, 32'd50,         32'd0,        8'd12},
        '{8'h58, 64'hA5A5A5A55A5A5A5A, 1'b0, 32'h01020304,   32'd0,        8'd20},
        '{8'h44, 64'h8000000000000001, 1'b0, 32'd0,          32'd0,        8'd5},
        '{8'h45, 64'h7766554433221100, 1'b1, 32'd7,          32'd123,      8'd0}
    };

    task automatic chk_eq(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int msg_len(logic [7:0] t);
        case (t)
            8'h41:   return 36;
            8'h45:   return 31;
            8'h58:   return 23;
            8'h44:   return 19;
            default: return 30;
        endcase
    endfunction

    function automatic string req_of(logic [7:0] t);
        case (t)
            8'h41:   return "R2";
            8'h45:   return "R3";
            8'h58:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic drive_idle();
        in_valid = 1'b0; in_sop = 1'b0; in_byte = 8'h00;
    endtask

    task automatic send_byte(logic [7:0] b, bit sop);
        @(negedge clk);
        in_valid = 1'b1; in_sop = sop; in_byte = b;
    endtask

    // builds the message from its fields; gap > 0 inserts two ignored cycles before that byte
    task automatic send_msg(logic [7:0] t, logic [63:0] r, logic s, logic [31:0] q,
                            logic [31:0] p, int gap, int upto);
        logic [7:0] b [36];
        int n;
        for (int i = 0; i < 36; i++) b[i] = 8'h20 + 8'(i);
        b[0] = t;
        for (int i = 0; i < 8; i++) b[11+i] = r[63-8*i -: 8];
        if (t == 8'h41) begin
            b[19] = s ? 8'h53 : 8'h42;
            for (int i = 0; i < 4; i++) begin
                b[20+i] = q[31-8*i -: 8];
                b[32+i] = p[31-8*i -: 8];
            end
        end else if (t == 8'h45 || t == 8'h58) begin
            for (int i = 0; i < 4; i++) b[19+i] = q[31-8*i -: 8];
        end
        n = msg_len(t);
        if (upto < n) n = upto;
        for (int i = 0; i < n; i++) begin
            if (gap != 0 && i == gap) begin
                repeat (2) begin
                    @(negedge clk);
                    in_valid = 1'b0; in_sop = 1'b1; in_byte = 8'hAA;
                end
            end
            send_byte(b[i], i == 0);
        end
    endtask

    task automatic expect_evt(logic [7:0] t, logic [63:0] r, logic s, logic [31:0] q,
                              logic [31:0] p);
        string rq;
        rq = req_of(t);
        @(negedge clk);
        drive_idle();
        chk_eq({rq, " R6 evt_valid"}, 64'(evt_valid), 64'd1);
        chk_eq({rq, " R6 evt_type"}, 64'(evt_type), 64'(t));
        chk_eq({rq, " R7 evt_ref"}, evt_ref, r);
        chk_eq({rq, " evt_sell"}, 64'(evt_sell), 64'(t == 8'h41 && s));
        chk_eq({rq, " R7 evt_shares"}, 64'(evt_shares), (t == 8'h44) ? 64'd0 : 64'(q));
        chk_eq({rq, " R7 evt_price"}, 64'(evt_price), (t == 8'h41) ? 64'(p) : 64'd0);
        @(negedge clk);
        chk_eq("R6 single-cycle strobe", 64'(evt_valid), 64'd0);
        chk_eq("R6 idle fields zero", evt_ref | 64'(evt_shares) | 64'(evt_price), 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int c0;
        rst_n = 1'b0;
        drive_idle();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_eq("R1 evt_valid", 64'(evt_valid), 64'd0);
        chk_eq("R1 fields", evt_ref | 64'(evt_shares) | 64'(evt_price) | 64'(evt_type)
               | 64'(evt_sell), 64'd0);

        // table walk: R2..R5 decoding, R7 byte order, R11 gap cycles inside messages
        for (int k = 0; k < 6; k++) begin
            send_msg(VEC[k].t, VEC[k].r, VEC[k].s, VEC[k].q, VEC[k].p, int'(VEC[k].gap), 99);
            expect_evt(VEC[k].t, VEC[k].r, VEC[k].s, VEC[k].q, VEC[k].p);
        end

        // R8: unknown type consumed silently, then a delete decodes normally
        c0 = ev_cnt;
        send_msg(8'h51, 64'h1111, 1'b0, 32'd9, 32'd9, 0, 99);
        drive_idle();
        repeat (3) @(negedge clk);
        chk_eq("R8 no event for unknown type", 64'(ev_cnt - c0), 64'd0);
        send_msg(8'h44, 64'h0000BEEF00000042, 1'b0, 32'd0, 32'd0, 0, 99);
        expect_evt(8'h44, 64'h0000BEEF00000042, 1'b0, 32'd0, 32'd0);

        // R9: interrupted add, then a full cancel
        c0 = ev_cnt;
        send_msg(8'h41, 64'hDEADDEADDEADDEAD, 1'b1, 32'd555, 32'd777, 0, 22);
        send_msg(8'h58, 64'h0102030405060708, 1'b0, 32'd33, 32'd0, 0, 99);
        expect_evt(8'h58, 64'h0102030405060708, 1'b0, 32'd33, 32'd0);
        chk_eq("R9 only the restarted message fires", 64'(ev_cnt - c0), 64'd1);

        // R10: trailing bytes without a start marker are dropped
        c0 = ev_cnt;
        for (int i = 0; i < 40; i++) send_byte(8'h41, 1'b0);
        drive_idle();
        repeat (3) @(negedge clk);
        chk_eq("R10 stray bytes give no event", 64'(ev_cnt - c0), 64'd0);

        // R6: back-to-back deletes, second start byte in the event cycle
        c0 = ev_cnt;
        send_msg(8'h44, 64'h00000000000000AA, 1'b0, 32'd0, 32'd0, 0, 99);
        send_msg(8'h44, 64'h00000000000000BB, 1'b0, 32'd0, 32'd0, 0, 99);
        expect_evt(8'h44, 64'h00000000000000BB, 1'b0, 32'd0, 32'd0);
        chk_eq("R6 back-to-back event count", 64'(ev_cnt - c0), 64'd2);

        // R1: reset in mid-message discards it
        c0 = ev_cnt;
        send_msg(8'h45, 64'h5, 1'b0, 32'd5, 32'd0, 0, 30);
        @(negedge clk);
        drive_idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        send_byte(8'h45, 1'b0);
        @(negedge clk);
        drive_idle();
        repeat (2) @(negedge clk);
        chk_eq("R1 reset drops partial message", 64'(ev_cnt - c0), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule